// File: doc/BRIEF.md
# Reload-Based Periodic Interrupt Timer

This block produces a steady interrupt rate from a slow reference. A one-cycle tick enable, pulsed at 32768 Hz by a prescaler elsewhere on the chip, drives a down counter. The counter restarts from a software-chosen reload value every time it runs out. Software picks an interrupt rate f by writing the reload value 32768/f. It then starts the timer by setting an enable bit in the control register. Writing the reload value never starts the timer by itself.

Each expiry sets the periodic bit (bit 1) of a small raw/mask/clear status group. A level interrupt goes out when that bit is both raised and unmasked. The reload value is locked while the timer runs. A rejected write leaves a sticky error bit in the control register, so software can tell that its new rate was not accepted. All register access is a single-cycle write port plus a combinational read port.

Top module: `ptmr_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is low.
- R2: While the timer is disabled, a write to the reload register at 0x24 stores the low 16 bits of the data, and 0x24 reads that value back.
- R3: While the timer is enabled, a write to 0x24 leaves the reload value unchanged and sets the sticky error bit (control bit 2). A control write with bit 2 set clears that bit.
- R4: The timer starts only on a control write (0x28) that sets bit 1 while the timer is disabled. That write loads the count, read at 0x20, with the reload value. Control bit 0 (self-start) reads 0 and has no effect, and a reload write does not start the timer.
- R5: While enabled, each cycle with `tick_en` high lowers a count above 1 by exactly one. Cycles without `tick_en` leave the count alone.
- R6: A tick that finds the count at 1 sets the raw periodic bit (bit 1 of 0x14) and reloads the count with the reload value in the same cycle.
- R7: Clearing control bit 1 stops the count at once. It holds its value, and ticks do not change it.
- R8: A reload value of 0 acts as 1. The count reads 1 while running, and every tick raises the periodic bit.
- R9: Writing 0x1C with bit 1 set clears the raw periodic bit. If an expiry happens in the same cycle, the bit stays set.
- R10: Mask bit 1 at 0x10 is read/write. 0x18 reads raw AND mask at bit 1, and `irq` is high exactly when that bit is set. The raw view at 0x14 does not depend on the mask.
- R11: Bit 0 of the three status views always reads 0. 0x1C reads 0. Addresses that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Masked periodic interrupt, level |

## Verification
The assertions assume one register write per cycle, so a control write never lands in the same cycle as a reload or clear write. They also assume `tick_en` is a plain level that is sampled on every edge. The bench keeps to this by driving a single write strobe from tasks. It drives ticks independently of writes, including on purpose in the same cycle as a control or clear write. The bench uses small reload values so that expiries, same-cycle clear collisions and zero-reload behaviour all occur within a short run.

// File: rtl/ptmr_pkg.sv
// Package: shared address map, bit positions and write-decode type for the
// periodic timer. Assumes byte addressing with word-aligned registers.
package ptmr_pkg;

    localparam int ADDR_W       = 8;

    localparam logic [ADDR_W-1:0] ADDR_MASK  = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_RAW   = 8'h14;
    localparam logic [ADDR_W-1:0] ADDR_MSKD  = 8'h18;
    localparam logic [ADDR_W-1:0] ADDR_CLR   = 8'h1C;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 8'h20;
    localparam logic [ADDR_W-1:0] ADDR_LOAD  = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h28;

    localparam int BIT_PER      = 1;   // periodic bit in status group
    localparam int CTRL_SELF    = 0;   // self-start, tied off
    localparam int CTRL_EN      = 1;   // run enable
    localparam int CTRL_ERR     = 2;   // sticky rejected-load flag

    typedef struct packed {
        logic mask;
        logic clr;
        logic ctrl;
        logic load;
    } wr_dec_t;

endpackage

// File: rtl/ptmr_regif.sv
// Register interface: decodes the single write port into per-register
// strobes and multiplexes the read port. Assumes at most one write per cycle.
module ptmr_regif
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                en_q,
    input  logic                err_q,
    input  logic [CNT_W-1:0]    load_q,
    input  logic [CNT_W-1:0]    count_q,
    input  logic                raw_q,
    input  logic                mask_q,
    output wr_dec_t             dec,
    output logic [DATA_W-1:0]   rd_data
);

    logic [DATA_W-1:0] count_ext;
    logic [DATA_W-1:0] load_ext;

    // Width adaptation of counter-sized fields onto the data bus.
    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_q};
            assign load_ext  = {{(DATA_W-CNT_W){1'b0}}, load_q};
        end else begin : g_trim
            assign count_ext = count_q[DATA_W-1:0];
            assign load_ext  = load_q[DATA_W-1:0];
        end
    endgenerate

    // Write strobe decode.
    always_comb begin
        dec.mask = wr_en && (wr_addr == ADDR_MASK);
        dec.clr  = wr_en && (wr_addr == ADDR_CLR);
        dec.ctrl = wr_en && (wr_addr == ADDR_CTRL);
        dec.load = wr_en && (wr_addr == ADDR_LOAD);
    end

    // Read multiplexer; unmapped and write-only addresses return zero.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_MASK:  rd_data[BIT_PER] = mask_q;
            ADDR_RAW:   rd_data[BIT_PER] = raw_q;
            ADDR_MSKD:  rd_data[BIT_PER] = raw_q & mask_q;
            ADDR_COUNT: rd_data = count_ext;
            ADDR_LOAD:  rd_data = load_ext;
            ADDR_CTRL: begin
                rd_data[CTRL_EN]  = en_q;
                rd_data[CTRL_ERR] = err_q;
            end
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ptmr_ctrl.sv
// Control and reload register: holds the run enable, the sticky error bit
// and the reload value. Locks the reload value while running and produces
// the start pulse and the effective (never zero) reload value.
module ptmr_ctrl
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_dec_t             dec,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                en_q,
    output logic                err_q,
    output logic [CNT_W-1:0]    load_q,
    output logic                start,
    output logic [CNT_W-1:0]    reload_val
);

    // Start only on a disabled-to-enabled control write.
    assign start      = dec.ctrl && wr_data[CTRL_EN] && !en_q;
    // Zero reload behaves as one.
    assign reload_val = (load_q == '0) ? CNT_W'(1) : load_q;

    // Run enable follows control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= 1'b0;
        else if (dec.ctrl) en_q <= wr_data[CTRL_EN];
    end

    // Reload value accepted only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                 load_q <= '0;
        else if (dec.load && !en_q) load_q <= wr_data[CNT_W-1:0];
    end

    // Sticky error: set by a rejected reload write, cleared by control bit 2.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err_q <= 1'b0;
        else if (dec.load && en_q)                   err_q <= 1'b1;
        else if (dec.ctrl && wr_data[CTRL_ERR])      err_q <= 1'b0;
    end

endmodule

// File: rtl/ptmr_count.sv
// Down counter: loads on start, steps on reference ticks while enabled,
// and reloads on expiry. Assumes reload_val is never zero.
module ptmr_count #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                en_q,
    input  logic                start,
    input  logic [CNT_W-1:0]    reload_val,
    output logic [CNT_W-1:0]    count_q,
    output logic                expire
);

    logic at_end;

    assign at_end = (count_q <= CNT_W'(1));
    // Expiry: enabled tick at the last count, not overridden by a start.
    assign expire = en_q && tick && !start && at_end;

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (start)          count_q <= reload_val;
        else if (en_q && tick)   count_q <= at_end ? reload_val : count_q - CNT_W'(1);
    end

endmodule

// File: rtl/ptmr_irq.sv
// Interrupt status for the periodic source: raw flag, mask bit and
// write-one-to-clear. A same-cycle expiry wins over a clear.
module ptmr_irq
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_dec_t             dec,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                expire,
    output logic                raw_q,
    output logic                mask_q,
    output logic                irq
);

    assign irq = raw_q & mask_q;

    // Raw flag: set on expiry, cleared by writing one to its clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              raw_q <= 1'b0;
        else if (expire)                         raw_q <= 1'b1;
        else if (dec.clr && wr_data[BIT_PER])    raw_q <= 1'b0;
    end

    // Mask bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= 1'b0;
        else if (dec.mask) mask_q <= wr_data[BIT_PER];
    end

endmodule

// File: rtl/ptmr_top.sv
// Periodic interrupt timer top: joins register interface, control,
// counter and interrupt status. Assumes tick_en is one cycle wide per
// reference period and CNT_W does not exceed DATA_W.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [7:0]          rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);

    wr_dec_t            dec;
    logic               en_q;
    logic               err_q;
    logic [CNT_W-1:0]   load_q;
    logic               start;
    logic [CNT_W-1:0]   reload_val;
    logic [CNT_W-1:0]   count_q;
    logic               expire;
    logic               raw_q;
    logic               mask_q;

    ptmr_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .en_q    (en_q),
        .err_q   (err_q),
        .load_q  (load_q),
        .count_q (count_q),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .dec     (dec),
        .rd_data (rd_data)
    );

    ptmr_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .wr_data    (wr_data),
        .en_q       (en_q),
        .err_q      (err_q),
        .load_q     (load_q),
        .start      (start),
        .reload_val (reload_val)
    );

    ptmr_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .en_q       (en_q),
        .start      (start),
        .reload_val (reload_val),
        .count_q    (count_q),
        .expire     (expire)
    );

    ptmr_irq #(.DATA_W(DATA_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wr_data (wr_data),
        .expire  (expire),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

endmodule

// File: rtl/ptmr_checker.sv
// Checker: temporal properties of the periodic timer, bound to ptmr_top.
// Assumes one write per cycle on the shared write port.
module ptmr_checker
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                en_q,
    input logic                err_q,
    input logic [CNT_W-1:0]    load_q,
    input logic [CNT_W-1:0]    count_q,
    input logic                raw_q,
    input logic                mask_q,
    input logic                irq
);

    logic ctrl_wr, load_wr, clr_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign load_wr = wr_en && (wr_addr == ADDR_LOAD);
    assign clr_wr  = wr_en && (wr_addr == ADDR_CLR);

    assert_load_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr && en_q |=> $stable(load_q) && err_q);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && tick && !ctrl_wr && (count_q > CNT_W'(1)) |=> count_q == $past(count_q) - CNT_W'(1));

    assert_expiry_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && tick && !ctrl_wr && (count_q == CNT_W'(1)) |=> raw_q);

    assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && !ctrl_wr |=> $stable(count_q));

    assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> count_q != '0);

    assert_clear_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && wr_data[BIT_PER] && !(en_q && tick && count_q <= CNT_W'(1)) |=> !raw_q);

    assert_mask_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq);

endmodule

bind ptmr_top ptmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_q    (en_q),
    .err_q   (err_q),
    .load_q  (load_q),
    .count_q (count_q),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq     (irq)
);

// File: tb/tb_ptmr_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against rd_data and irq one time unit later, every cycle.
module tb_ptmr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    int m_load = 0, m_cnt = 0, m_en = 0, m_err = 0, m_raw = 0, m_mask = 0;

    always #2 clk = ~clk;

    ptmr_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic int model_rd(input logic [7:0] a);
        case (a)
            8'h10: return m_mask << 1;
            8'h14: return m_raw << 1;
            8'h18: return (m_raw & m_mask) << 1;
            8'h20: return m_cnt;
            8'h24: return m_load;
            8'h28: return (m_en << 1) | (m_err << 2);
            default: return 0;
        endcase
    endfunction

    // Reference model step plus comparison after the edge settles.
    always @(posedge clk) begin
        int start, expd, eff;
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_en = 0; m_err = 0; m_raw = 0; m_mask = 0;
        end else begin
            eff   = (m_load == 0) ? 1 : m_load;
            start = (wr_en && wr_addr == 8'h28 && wr_data[1] && m_en == 0) ? 1 : 0;
            expd  = (start == 0 && m_en == 1 && tick_en && m_cnt <= 1) ? 1 : 0;
            if (start == 1) m_cnt = eff;
            else if (m_en == 1 && tick_en) m_cnt = (m_cnt <= 1) ? eff : m_cnt - 1;
            if (wr_en) begin
                case (wr_addr)
                    8'h28: begin
                        if (wr_data[2]) m_err = 0;
                        m_en = wr_data[1];
                    end
                    8'h24: if (m_en == 1) m_err = 1; else m_load = int'(wr_data[15:0]);
                    8'h10: m_mask = wr_data[1];
                    8'h1C: if (wr_data[1]) m_raw = 0;
                    default: ;
                endcase
            end
            if (expd == 1) m_raw = 1;
        end
        #1;
        total++;
        if (rd_data !== 32'(model_rd(rd_addr))) begin
            bad++;
            $display("FAIL %s rd_addr=%h actual=%h expected=%h", cur_req, rd_addr, rd_data, 32'(model_rd(rd_addr)));
        end
        total++;
        if (irq !== 1'((m_raw & m_mask) != 0)) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, (m_raw & m_mask) != 0);
        end
    end

    task automatic cyc(input logic tk);
        wr_en = 1'b0; tick_en = tk;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic look(input logic [7:0] a, input int n);
        rd_addr = a;
        for (int i = 0; i < n; i++) cyc(1'b0);
    endtask

    task automatic sweep();
        look(8'h10, 1); look(8'h14, 1); look(8'h18, 1); look(8'h1C, 1);
        look(8'h20, 1); look(8'h24, 1); look(8'h28, 1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";  sweep();
        cur_req = "R11"; look(8'h04, 1); look(8'h2C, 1); look(8'h30, 1); look(8'hFC, 1);
        // R2: reload write while stopped
        cur_req = "R2";  wr(8'h24, 32'hABCD_0005, 1'b0); look(8'h24, 2);
        // R4: self-start bit and reload write do not start
        cur_req = "R4";  wr(8'h28, 32'h1, 1'b0); rd_addr = 8'h20;
        cyc(1'b1); cyc(1'b1); look(8'h28, 1);
        wr(8'h24, 32'h5, 1'b1); look(8'h20, 1);
        wr(8'h28, 32'h2, 1'b1); look(8'h20, 1);
        // R5: stepping with gaps
        cur_req = "R5";  rd_addr = 8'h20;
        cyc(1'b1); cyc(1'b0); cyc(1'b1); cyc(1'b0); cyc(1'b0); cyc(1'b1);
        // R6: expiry and reload
        cur_req = "R6";  cyc(1'b1); cyc(1'b1); look(8'h14, 1); look(8'h20, 1);
        // R3: reload write while running
        cur_req = "R3";  wr(8'h24, 32'h9, 1'b0); look(8'h24, 1); look(8'h28, 1);
        wr(8'h28, 32'h6, 1'b0); look(8'h28, 1); look(8'h24, 1);
        // R9: clear, then clear colliding with expiry
        cur_req = "R9";  wr(8'h1C, 32'h2, 1'b0); look(8'h14, 1);
        rd_addr = 8'h20; cyc(1'b1); cyc(1'b1); cyc(1'b1); cyc(1'b1);
        rd_addr = 8'h14; wr(8'h1C, 32'h2, 1'b1); look(8'h14, 1);
        wr(8'h1C, 32'h1, 1'b0); look(8'h14, 1);
        // R10: mask gating
        cur_req = "R10"; look(8'h18, 1); wr(8'h10, 32'h2, 1'b0); look(8'h18, 1); look(8'h10, 1);
        wr(8'h1C, 32'h2, 1'b0); look(8'h18, 1); look(8'h14, 1);
        wr(8'h10, 32'h0, 1'b0); rd_addr = 8'h14;
        for (int i = 0; i < 6; i++) cyc(1'b1);
        // R7: stop holds the count
        cur_req = "R7";  rd_addr = 8'h20; cyc(1'b1); wr(8'h28, 32'h0, 1'b1);
        cyc(1'b1); cyc(1'b1); cyc(1'b0); look(8'h28, 1);
        // R8: zero reload
        cur_req = "R8";  wr(8'h24, 32'h0, 1'b0); wr(8'h10, 32'h2, 1'b0);
        wr(8'h28, 32'h2, 1'b0); rd_addr = 8'h20; cyc(1'b1);
        wr(8'h1C, 32'h2, 1'b0); cyc(1'b1); look(8'h14, 1);
        wr(8'h1C, 32'h2, 1'b0); rd_addr = 8'h18; cyc(1'b1); cyc(1'b0);
        // Mixed random traffic, compared every cycle
        cur_req = "R5";
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = int'($urandom % 16);
            rd_addr = 8'h10 + 8'(4 * ($urandom % 7));
            case (r)
                0: wr(8'h24, 32'($urandom % 6), 1'($urandom % 2));
                1: wr(8'h28, 32'($urandom % 8), 1'($urandom % 2));
                2: wr(8'h1C, 32'($urandom % 4), 1'($urandom % 2));
                3: wr(8'h10, 32'($urandom % 4), 1'($urandom % 2));
                default: cyc(1'($urandom % 3 == 0));
            endcase
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule